// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a fixed set of sources and hands them to a processor one at a time. Each source has a fixed rank: hardware failure first, then program faults, then the internal timer, then I/O completion or error. The processor sees a single request line, answers it with an acknowledge, reads the winning source's ID from a vector output, and signals end of service when its handler is finished.

Two dispatch policies are chosen at run time. In sequential mode, nothing new reaches the processor while a service is open. New arrivals are latched as pending, and after the service ends they are presented in the order in which they arrived. In nested mode, a pending source that outranks the one currently being serviced raises the request line at once and preempts it. Sources of lower rank wait. When a nested service ends, the controller returns to the level it interrupted.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is held low, and after it is released with no request present, `irq_o` is 0, `vec_o` is 0 and `vec_vld_o` is 0.
- R2: Source IDs are the bit indices of `src_req`: 0 is hardware failure, 1 is program fault, 2 is timer and 3 is I/O. A lower ID has higher rank. A request seen high at a clock edge, from a source that is neither pending nor in service, becomes pending at that edge, and the request line can rise in the next cycle.
- R3: In sequential mode (`nest_mode` = 0), `irq_o` stays 0 while a service is open, and at most one service is open at a time.
- R4: In sequential mode, pending sources are presented in order of arrival. Sources that become pending at the same edge are queued in ascending ID order, and a source is never queued twice.
- R5: In nested mode (`nest_mode` = 1), `irq_o` is 1 exactly when the lowest pending ID is lower than the ID of the innermost open service, or when a source is pending and no service is open.
- R6: In nested mode, an end of service closes the innermost open service, and `vec_o` then shows the level that was preempted.
- R7: While `irq_o` is 1, `vec_o` holds the ID being offered. Otherwise, while a service is open, it holds the innermost open ID. `vec_vld_o` is 1 in both cases. With neither, both outputs are 0.
- R8: An acknowledge while `irq_o` is 0, or an end of service while no service is open, changes nothing.
- R9: When acknowledge and end of service come in the same cycle and a service is open, the end of service takes effect. The acknowledge is dropped, and the offered source stays pending.
- R10: A request from a source that is in service is not latched. If that request is still high after its end of service, it becomes pending at the following edge.
- R11: An acknowledge taken while `irq_o` is 1 clears the offered source's pending state and opens its service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nest_mode | input | 1 | 0 selects sequential dispatch, 1 selects nested dispatch |
| src_req | input | N_SRC | Level request per source, indexed by source ID |
| irq_ack | input | 1 | Processor acknowledge of the offered request |
| svc_done | input | 1 | Processor end of service for the innermost open service |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | $clog2(N_SRC) | Source ID being offered or serviced |
| vec_vld_o | output | 1 | `vec_o` carries a live ID |

## Verification
The assertions assume that `nest_mode` changes only while the controller is idle, meaning nothing is pending and no service is open. The sequential arrival queue is not kept in nested mode, so a switch at any other time leaves the queue inconsistent. The bench changes the mode only at points where its reference model holds no pending source, no queued ID and no open service. It may still assert acknowledge and end of service at any moment, including stray and coincident pulses, because those cases are part of the defined behaviour.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   // dispatch policy chosen at run time
   typedef enum logic {
      POL_SEQ  = 1'b0,
      POL_NEST = 1'b1
   } policy_e;

endpackage

// File: rtl/irq_pend_track.sv
// Pending-state capture per source plus the arrival-order queue used in
// sequential dispatch.
module irq_pend_track
   import irq_nest_pkg::*;
#(
   parameter int N_SRC      = 4,
   parameter int FIFO_DEPTH = 4,
   parameter int IDW        = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  policy_e          policy,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] isv,
   input  logic             take,
   input  logic [IDW-1:0]   take_id,
   output logic [N_SRC-1:0] pend_o,
   output logic [IDW-1:0]   head_o,
   output logic             queued_o
);

   localparam int PW = $clog2(FIFO_DEPTH);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] fresh;
   logic             enq_en;
   logic             pop;
   logic [CW-1:0]    offs [N_SRC];
   logic [CW-1:0]    nnew;

   logic [IDW-1:0]   slot_q [FIFO_DEPTH];
   logic [PW-1:0]    rd_q;
   logic [PW-1:0]    wr_q;
   logic [CW-1:0]    cnt_q;

   // a source becomes pending only when idle in both senses
   assign fresh  = src_req & ~pend_q & ~isv;
   assign enq_en = (policy == POL_SEQ);
   assign pop    = take & (policy == POL_SEQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         for (int i = 0; i < N_SRC; i++) begin
            if (fresh[i]) begin
               pend_q[i] <= 1'b1;
            end else if (take && (take_id == IDW'(i))) begin
               pend_q[i] <= 1'b0;
            end
         end
      end
   end

   // slot offset of each newcomer, ascending ID order within one edge
   always_comb begin
      nnew = '0;
      for (int i = 0; i < N_SRC; i++) begin
         offs[i] = nnew;
         if (enq_en && fresh[i]) begin
            nnew = nnew + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         for (int j = 0; j < FIFO_DEPTH; j++) begin
            slot_q[j] <= '0;
         end
      end else begin
         rd_q  <= rd_q + PW'(pop);
         wr_q  <= wr_q + PW'(nnew);
         cnt_q <= cnt_q + nnew - CW'(pop);
         for (int i = 0; i < N_SRC; i++) begin
            if (enq_en && fresh[i]) begin
               slot_q[wr_q + PW'(offs[i])] <= IDW'(i);
            end
         end
      end
   end

   assign pend_o   = pend_q;
   assign head_o   = slot_q[rd_q];
   assign queued_o = (cnt_q != '0);

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-rank selector: the lowest set index wins.
module irq_prio_pick #(
   parameter int N_SRC = 4,
   parameter int IDW   = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req_vec,
   output logic             any_o,
   output logic [IDW-1:0]   id_o
);

   always_comb begin
      any_o = |req_vec;
      id_o  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req_vec[i]) begin
            id_o = IDW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_svc_stack.sv
// Stack of open service levels with a matching in-service bit vector.
module irq_svc_stack #(
   parameter int N_SRC = 4,
   parameter int IDW   = $clog2(N_SRC),
   parameter int DW    = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDW-1:0]   push_id,
   input  logic             pop,
   output logic [DW-1:0]    depth_o,
   output logic [IDW-1:0]   top_o,
   output logic [N_SRC-1:0] isv_o
);

   logic [IDW-1:0]   lvl_q [N_SRC];
   logic [DW-1:0]    depth_q;
   logic [N_SRC-1:0] isv_q;
   logic [IDW-1:0]   top_idx;

   assign top_idx = IDW'(depth_q - 1'b1);
   assign top_o   = (depth_q == '0) ? '0 : lvl_q[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         isv_q   <= '0;
         for (int j = 0; j < N_SRC; j++) begin
            lvl_q[j] <= '0;
         end
      end else if (pop) begin
         depth_q       <= depth_q - 1'b1;
         isv_q[top_o]  <= 1'b0;
      end else if (push) begin
         lvl_q[IDW'(depth_q)] <= push_id;
         depth_q              <= depth_q + 1'b1;
         isv_q[push_id]       <= 1'b1;
      end
   end

   assign depth_o = depth_q;
   assign isv_o   = isv_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int N_SRC      = 4,
   parameter int FIFO_DEPTH = 4,
   localparam int IDW       = $clog2(N_SRC),
   localparam int DW        = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nest_mode,
   input  logic [N_SRC-1:0] src_req,
   input  logic             irq_ack,
   input  logic             svc_done,
   output logic             irq_o,
   output logic [IDW-1:0]   vec_o,
   output logic             vec_vld_o
);

   // elaboration-time parameter checks
   generate
      if (N_SRC < 2) begin : g_bad_nsrc
         $error("irq_nest_ctrl: N_SRC must be at least 2");
      end
      if (FIFO_DEPTH < N_SRC) begin : g_bad_depth
         $error("irq_nest_ctrl: FIFO_DEPTH must cover every source");
      end
      if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("irq_nest_ctrl: FIFO_DEPTH must be a power of two");
      end
   endgenerate

   policy_e          policy;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] isv;
   logic [IDW-1:0]   fifo_head;
   logic             fifo_any;
   logic             pick_any;
   logic [IDW-1:0]   pick_id;
   logic [DW-1:0]    depth;
   logic [IDW-1:0]   top_id;
   logic             busy;
   logic             done_take;
   logic             ack_take;
   logic             nest_ok;
   logic [IDW-1:0]   cand;

   assign policy = nest_mode ? POL_NEST : POL_SEQ;

   irq_pend_track #(
      .N_SRC      (N_SRC),
      .FIFO_DEPTH (FIFO_DEPTH),
      .IDW        (IDW)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .policy   (policy),
      .src_req  (src_req),
      .isv      (isv),
      .take     (ack_take),
      .take_id  (cand),
      .pend_o   (pend),
      .head_o   (fifo_head),
      .queued_o (fifo_any)
   );

   irq_prio_pick #(
      .N_SRC (N_SRC),
      .IDW   (IDW)
   ) u_pick (
      .req_vec (pend),
      .any_o   (pick_any),
      .id_o    (pick_id)
   );

   irq_svc_stack #(
      .N_SRC (N_SRC),
      .IDW   (IDW),
      .DW    (DW)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (ack_take),
      .push_id (cand),
      .pop     (done_take),
      .depth_o (depth),
      .top_o   (top_id),
      .isv_o   (isv)
   );

   assign busy      = (depth != '0);
   assign done_take = svc_done & busy;
   assign nest_ok   = pick_any & (~busy | (pick_id < top_id));

   always_comb begin
      if (policy == POL_NEST) begin
         irq_o = nest_ok;
         cand  = pick_id;
      end else begin
         irq_o = ~busy & fifo_any;
         cand  = fifo_head;
      end
   end

   assign ack_take  = irq_o & irq_ack & ~done_take;
   assign vec_o     = irq_o ? cand : (busy ? top_id : '0);
   assign vec_vld_o = irq_o | busy;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
   parameter int N_SRC = 4,
   parameter int IDW   = 2,
   parameter int DW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             nest_mode,
   input logic             irq_ack,
   input logic             svc_done,
   input logic             irq_o,
   input logic [IDW-1:0]   vec_o,
   input logic             vec_vld_o,
   input logic [DW-1:0]    depth,
   input logic [IDW-1:0]   top_id,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] isv
);

   AST_SEQ_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !nest_mode |-> depth <= DW'(1)); // R3

   AST_ACK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && irq_ack && !(svc_done && depth != '0)) |=> depth == $past(depth) + 1'b1); // R11

   AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && irq_ack && !(svc_done && depth != '0)) |=> !pend[$past(vec_o)]); // R11

   AST_NEST_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (nest_mode && irq_o && depth != '0) |-> vec_o < top_id); // R5

   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_done && depth != '0) |=> depth == $past(depth) - 1'b1); // R6

   AST_VLD_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      depth != '0 |-> vec_vld_o); // R7

   AST_NO_PEND_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & isv) == '0); // R10

   AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_done && depth == '0 && !irq_o) |=> depth == '0); // R8

   AST_OPEN_MATCHES_ISV: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isv) == int'(depth)); // R6

endmodule

bind irq_nest_ctrl irq_nest_chk #(
   .N_SRC (N_SRC),
   .IDW   (IDW),
   .DW    (DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nest_mode (nest_mode),
   .irq_ack   (irq_ack),
   .svc_done  (svc_done),
   .irq_o     (irq_o),
   .vec_o     (vec_o),
   .vec_vld_o (vec_vld_o),
   .depth     (depth),
   .top_id    (top_id),
   .pend      (pend),
   .isv       (isv)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         nest_mode = 1'b0;
   logic [N-1:0] src_req = '0;
   logic         irq_ack = 1'b0;
   logic         svc_done = 1'b0;
   logic         irq_o;
   logic [1:0]   vec_o;
   logic         vec_vld_o;

   int    n_checks = 0;
   int    n_errors = 0;
   int    cyc = 0;
   string cur_tag = "R1";

   // reference model state
   bit m_pend [N];
   bit m_isv  [N];
   int m_fifo [$];
   int m_stk  [$];

   always #5 clk = ~clk;

   irq_nest_ctrl #(.N_SRC(N), .FIFO_DEPTH(4)) i_irq_nest_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .nest_mode (nest_mode),
      .src_req   (src_req),
      .irq_ack   (irq_ack),
      .svc_done  (svc_done),
      .irq_o     (irq_o),
      .vec_o     (vec_o),
      .vec_vld_o (vec_vld_o)
   );

   function automatic bit m_busy();
      return m_stk.size() > 0;
   endfunction

   function automatic int m_low_pend();
      for (int i = 0; i < N; i++) if (m_pend[i]) return i;
      return -1;
   endfunction

   function automatic bit m_irq();
      int lp;
      if (nest_mode) begin
         lp = m_low_pend();
         return (lp >= 0) && (!m_busy() || lp < m_stk[$]);
      end
      return !m_busy() && m_fifo.size() > 0;
   endfunction

   function automatic int m_cand();
      if (nest_mode) return m_low_pend();
      return (m_fifo.size() > 0) ? m_fifo[0] : 0;
   endfunction

   function automatic int m_vec();
      if (m_irq()) return m_cand();
      if (m_busy()) return m_stk[$];
      return 0;
   endfunction

   function automatic bit m_idle();
      for (int i = 0; i < N; i++) if (m_pend[i]) return 1'b0;
      return !m_busy() && m_fifo.size() == 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_pend[i] = 1'b0;
            m_isv[i]  = 1'b0;
         end
         m_fifo.delete();
         m_stk.delete();
      end else begin
         bit fresh [N];
         bit irq_now;
         bit done_t;
         bit ack_t;
         int c;
         irq_now = m_irq();
         c       = m_cand();
         done_t  = svc_done && m_busy();
         ack_t   = irq_now && irq_ack && !done_t;
         for (int i = 0; i < N; i++) fresh[i] = src_req[i] && !m_pend[i] && !m_isv[i];
         if (done_t) begin
            m_isv[m_stk[$]] = 1'b0;
            void'(m_stk.pop_back());
         end
         if (ack_t) begin
            m_pend[c] = 1'b0;
            m_isv[c]  = 1'b1;
            m_stk.push_back(c);
            if (!nest_mode) void'(m_fifo.pop_front());
         end
         for (int i = 0; i < N; i++) begin
            if (fresh[i]) begin
               m_pend[i] = 1'b1;
               if (!nest_mode) m_fifo.push_back(i);
            end
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
      end
   endtask

   // one clock: compare against the model at the falling edge
   task automatic tick();
      @(negedge clk);
      cyc++;
      check(cur_tag, "irq_o", int'(irq_o), int'(m_irq()));
      check(cur_tag, "vec_vld_o", int'(vec_vld_o), int'(m_irq() || m_busy()));
      check(cur_tag, "vec_o", int'(vec_o), m_vec());
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      finish_up();
   end

   task automatic pulse_ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic pulse_done();
      svc_done = 1'b1; tick(); svc_done = 1'b0;
   endtask

   initial begin
      // R1 reset state
      cur_tag = "R1";
      repeat (3) tick();
      check("R1", "irq_o in reset", int'(irq_o), 0);
      check("R1", "vec_vld_o in reset", int'(vec_vld_o), 0);
      rst_n = 1'b1;
      repeat (2) tick();
      check("R1", "vec_o idle", int'(vec_o), 0);

      // sequential order: R3 and R4
      cur_tag = "R4";
      nest_mode = 1'b0;
      src_req = 4'b1100; tick();
      src_req = 4'b0010; tick();
      src_req = 4'b0000;
      check("R4", "first offered", int'(vec_o), 2);
      check("R2", "irq raised", int'(irq_o), 1);
      pulse_ack();
      cur_tag = "R3";
      src_req = 4'b0001; tick();
      src_req = 4'b0000;
      check("R3", "no irq while open", int'(irq_o), 0);
      check("R7", "vec shows open level", int'(vec_o), 2);
      pulse_done();
      check("R4", "second in arrival order", int'(vec_o), 3);
      pulse_ack(); pulse_done();
      check("R4", "third in arrival order", int'(vec_o), 1);
      pulse_ack(); pulse_done();
      check("R4", "late high rank last", int'(vec_o), 0);
      pulse_ack(); pulse_done();
      check("R11", "idle after queue drained", int'(vec_vld_o), 0);

      // nested preemption and return: R5, R6
      cur_tag = "R5";
      nest_mode = 1'b1;
      src_req = 4'b0100; tick();
      src_req = 4'b0000;
      check("R2", "timer offered", int'(vec_o), 2);
      pulse_ack();
      src_req = 4'b1000; tick();
      src_req = 4'b0000;
      check("R5", "lower rank waits", int'(irq_o), 0);
      src_req = 4'b0001; tick();
      src_req = 4'b0000;
      check("R5", "higher rank preempts", int'(irq_o), 1);
      check("R5", "preempting id", int'(vec_o), 0);
      pulse_ack();
      cur_tag = "R6";
      pulse_done();
      check("R6", "return to timer", int'(vec_o), 2);
      check("R6", "io still waits", int'(irq_o), 0);
      pulse_done();
      check("R5", "io offered when free", int'(vec_o), 3);
      pulse_ack(); pulse_done();

      // stray pulses: R8
      cur_tag = "R8";
      irq_ack = 1'b1; svc_done = 1'b1; tick();
      irq_ack = 1'b0; svc_done = 1'b0; tick();
      check("R8", "stray pulses ignored", int'(vec_vld_o), 0);

      // coincident ack and done: R9
      cur_tag = "R9";
      src_req = 4'b0100; tick(); src_req = 4'b0000;
      pulse_ack();
      src_req = 4'b0001; tick(); src_req = 4'b0000;
      irq_ack = 1'b1; svc_done = 1'b1; tick();
      irq_ack = 1'b0; svc_done = 1'b0;
      check("R9", "request kept", int'(irq_o), 1);
      check("R9", "kept id", int'(vec_o), 0);
      pulse_ack();
      check("R9", "served after retry", int'(irq_o), 0);
      pulse_done();

      // held request of a source in service: R10
      cur_tag = "R10";
      src_req = 4'b0100; tick();
      pulse_ack();
      check("R10", "held req not latched", int'(irq_o), 0);
      pulse_done();
      check("R10", "no repend at done edge", int'(vec_vld_o), 0);
      tick();
      check("R10", "repends after done", int'(vec_o), 2);
      src_req = 4'b0000;
      pulse_ack(); pulse_done();

      // random traffic, mode changes only when idle: R2 R3 R4 R5 R6 R7 R11
      cur_tag = "R7";
      for (int k = 0; k < 6000; k++) begin
         for (int i = 0; i < N; i++) src_req[i] = ($urandom_range(0, 5) == 0);
         irq_ack  = (m_irq() && $urandom_range(0, 2) == 0) || ($urandom_range(0, 9) == 0);
         svc_done = (m_busy() && $urandom_range(0, 3) == 0) || ($urandom_range(0, 11) == 0);
         tick();
         if (m_idle() && src_req == '0 && $urandom_range(0, 7) == 0) begin
            nest_mode = ~nest_mode;
         end
      end
      src_req = '0; irq_ack = 1'b0; svc_done = 1'b0;
      tick();
      finish_up();
   end

endmodule